// File: doc/BRIEF.md
# Authenticated-cipher output formatter with plaintext hold

This block sits after the cipher core of an authenticated-encryption engine. It builds the output word stream. Segment headers, and any segment that does not pass through the core (associated data, nonce and similar), arrive as words on a bypass channel. The block forwards them unchanged. Wide result blocks from the core are cut into data-width words, most significant word first. Bytes that lie past the end of the segment's stated length are cleared to zero, and the unused rest of the final block is dropped.

When encryption ends, the block appends a tag segment built from the core's tag, followed by a success status word. During decryption, the plaintext header and the plaintext words go into an internal hold FIFO, and none of them reach the output until the tag comparison result arrives. A passing result releases the held words in order, followed by a success status word. A failing result empties the FIFO and sends only a failure status word.

The output port uses a valid/ready handshake, so it can feed a plain FIFO or a streaming bus slave. The block accepts a new core block in the same cycle that the last word of the previous block leaves. This lets the core produce block n+1 while block n is being emitted.

Top module: `aead_pp_top`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is low and both `byp_ready` and `blk_ready` are high.
- R2: A header word carries the segment type in bits [W-1:W-4], the end-of-input flag in bit W-5, the end-of-type flag in bit W-6 and the byte length in bits [W-17:W-32]. All other bits are zero. Type codes are: associated data 0010, plaintext 0011, ciphertext 0100, tag 0101.
- R3: A header of any type other than plaintext or ciphertext is emitted unchanged. It is followed by ceil(len/(W/8)) words taken from the bypass channel and emitted unchanged.
- R4: A ciphertext header is emitted unchanged. It is followed by ceil(len/(W/8)) words cut from the core blocks, most significant word of each block first. Each block gives up to BLOCK_W/W words.
- R5: In an emitted core word, each byte at or beyond the segment length is zero (byte 0 is the most significant byte of a word). Block words past the segment end are never emitted.
- R6: After a ciphertext segment whose end-of-type flag is set, the block emits a tag header (type 0101, end-of-input 1, end-of-type 1, length TAG_W/8). Then come the tag words, most significant first, and then the success status word. This also holds for a ciphertext length of zero.
- R7: A plaintext header and its words are held internally. No word is emitted while the block waits for the authentication result.
- R8: A passing result releases the held header and words in their original order, followed by the success status word. The status word has 1110 in bits [W-1:W-4] and zero elsewhere.
- R9: A failing result discards every held word. Only the failure status word (1111 in bits [W-1:W-4], zero elsewhere) is emitted, and no held word appears later.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged, and no word is lost or repeated.
- R11: With `out_ready` held high, a ciphertext segment that spans two blocks is emitted with no idle cycle between the header and the last word.

Notes on use:
- A held plaintext message (its header plus its words) must fit in AUX_DEPTH entries.
- The plaintext segments of one message arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byp_data | input | DATA_W | Bypass word: a segment header or a forwarded payload word |
| byp_valid | input | 1 | Bypass word is present |
| byp_ready | output | 1 | Bypass word is taken this cycle |
| blk_data | input | BLOCK_W | Result block from the cipher core |
| blk_valid | input | 1 | Result block is present |
| blk_ready | output | 1 | Result block is taken this cycle |
| tag_data | input | TAG_W | Computed tag from the cipher core |
| tag_valid | input | 1 | Tag is present |
| tag_ready | output | 1 | Tag is taken this cycle |
| auth_valid | input | 1 | Authentication result is present |
| auth_ok | input | 1 | 1 when the tag comparison passed |
| auth_ready | output | 1 | Authentication result is taken this cycle |
| out_data | output | DATA_W | Output word |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Downstream takes the output word |

## Verification
The bench builds the block with DATA_W=32, BLOCK_W=128, TAG_W=128 and AUX_DEPTH=16. With these values a block splits into four words. That makes it possible to test segments that end part-way through a word, segments that end part-way through a block, and segments that cross a block boundary. It also gives a four-word tag and a held message of up to fifteen data words. Random `out_ready` stalls are applied to the ciphertext, tag and bypass paths, and zero-length segments are exercised as well. A failing result is followed by a bypass segment, which exposes any held word that leaked through.

// File: rtl/aead_pp_pkg.sv
package aead_pp_pkg;

   localparam logic [3:0] SEG_AD   = 4'b0010;
   localparam logic [3:0] SEG_PT   = 4'b0011;
   localparam logic [3:0] SEG_CT   = 4'b0100;
   localparam logic [3:0] SEG_TAG  = 4'b0101;
   localparam logic [3:0] STAT_OK  = 4'b1110;
   localparam logic [3:0] STAT_BAD = 4'b1111;

   localparam int HDR_W = 32;
   localparam int LEN_W = 16;

   typedef enum logic [3:0] {
      S_IDLE,
      S_HDR,
      S_PASS,
      S_CT,
      S_TAGH,
      S_TAG,
      S_DMSG,
      S_WAUTH,
      S_DRAIN,
      S_STAT
   } pp_state_t;

endpackage

// File: rtl/aead_pp_piso.sv
module aead_pp_piso #(
   parameter int IN_W  = 128,
   parameter int W     = 32,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  in_data,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [LEN_W-1:0] rem,
   input  logic             take,
   output logic [W-1:0]     word_data,
   output logic             word_valid
);

   localparam int NW   = IN_W / W;
   localparam int BPW  = W / 8;
   localparam int IDXW = (NW > 1) ? $clog2(NW) : 1;

   if (IN_W % W != 0) begin : g_chk_div
      $error("aead_pp_piso: IN_W must be a multiple of W");
   end
   if (W % 8 != 0) begin : g_chk_byte
      $error("aead_pp_piso: W must be a whole number of bytes");
   end

   logic [NW-1:0][W-1:0] blk_q;
   logic                 full_q;
   logic [IDXW-1:0]      idx_q;
   logic [W-1:0]         cur;
   logic                 last_w;
   logic                 take_end;
   logic                 load;

   assign last_w   = (idx_q == IDXW'(NW - 1)) || (rem <= LEN_W'(BPW));
   assign take_end = take && full_q && last_w;
   assign in_ready = !full_q || take_end;
   assign load     = in_valid && in_ready;
   assign cur      = blk_q[IDXW'(NW - 1) - idx_q];

   for (genvar j = 0; j < BPW; j++) begin : g_byte
      assign word_data[W-1-8*j -: 8] = (rem > LEN_W'(j)) ? cur[W-1-8*j -: 8] : 8'h00;
   end
   assign word_valid = full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         idx_q  <= '0;
      end else if (load) begin
         full_q <= 1'b1;
         idx_q  <= '0;
      end else if (take_end) begin
         full_q <= 1'b0;
      end else if (take && full_q) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (load) blk_q <= in_data;
   end

   // R4: the controller only takes a word that is present
   assert_take_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full_q);

endmodule

// File: rtl/aead_pp_auxfifo.sv
module aead_pp_auxfifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   input  logic         flush,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_chk_depth
      $error("aead_pp_auxfifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [AW:0]   cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == (AW+1)'(DEPTH));
   assign head  = mem[rd_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_q] <= push_data;
   end

   // R7: a held word is never written into a full store
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R8: release never reads an empty store
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/aead_pp_top.sv
module aead_pp_top
   import aead_pp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int BLOCK_W   = 128,
   parameter int TAG_W     = 128,
   parameter int AUX_DEPTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  byp_data,
   input  logic               byp_valid,
   output logic               byp_ready,
   input  logic [BLOCK_W-1:0] blk_data,
   input  logic               blk_valid,
   output logic               blk_ready,
   input  logic [TAG_W-1:0]   tag_data,
   input  logic               tag_valid,
   output logic               tag_ready,
   input  logic               auth_valid,
   input  logic               auth_ok,
   output logic               auth_ready,
   output logic [DATA_W-1:0]  out_data,
   output logic               out_valid,
   input  logic               out_ready
);

   localparam int BPW = DATA_W / 8;
   localparam logic [LEN_W-1:0] TAG_BYTES = LEN_W'(TAG_W / 8);
   localparam logic [LEN_W-1:0] STEP      = LEN_W'(BPW);

   if (DATA_W < HDR_W || DATA_W % 8 != 0) begin : g_chk_w
      $error("aead_pp_top: DATA_W must be a byte multiple of at least 32");
   end
   if (BLOCK_W % DATA_W != 0 || TAG_W % DATA_W != 0) begin : g_chk_blk
      $error("aead_pp_top: BLOCK_W and TAG_W must be multiples of DATA_W");
   end

   pp_state_t state_q;
   logic [DATA_W-1:0] hdr_q;
   logic [LEN_W-1:0]  rem_q, rem_step;
   logic              eot_q, ok_q, last_step;

   logic [3:0]        in_type, hdr_type;
   logic              in_eot;
   logic [LEN_W-1:0]  in_len;

   logic [DATA_W-1:0] blk_word, tag_word, aux_head, aux_push_data;
   logic              blk_wvalid, tag_wvalid;
   logic              blk_take, tag_take;
   logic              aux_push, aux_pop, aux_flush, aux_empty, aux_full;
   logic [DATA_W-1:0] tag_hdr_word, stat_word;
   logic [HDR_W-1:0]  tag_hdr32;

   assign in_type  = byp_data[DATA_W-1 -: 4];
   assign in_eot   = byp_data[DATA_W-6];
   assign in_len   = byp_data[DATA_W-17 -: LEN_W];
   assign hdr_type = hdr_q[DATA_W-1 -: 4];

   assign rem_step  = (rem_q > STEP) ? rem_q - STEP : '0;
   assign last_step = (rem_q <= STEP);

   assign tag_hdr32 = {SEG_TAG, 1'b1, 1'b1, 10'b0, TAG_BYTES};
   if (DATA_W > HDR_W) begin : g_hdr_pad
      assign tag_hdr_word = {tag_hdr32, {(DATA_W-HDR_W){1'b0}}};
   end else begin : g_hdr_exact
      assign tag_hdr_word = tag_hdr32;
   end
   assign stat_word = {(ok_q ? STAT_OK : STAT_BAD), {(DATA_W-4){1'b0}}};

   aead_pp_piso #(.IN_W(BLOCK_W), .W(DATA_W), .LEN_W(LEN_W)) u_blk_piso (
      .clk(clk), .rst_n(rst_n),
      .in_data(blk_data), .in_valid(blk_valid), .in_ready(blk_ready),
      .rem(rem_q), .take(blk_take),
      .word_data(blk_word), .word_valid(blk_wvalid)
   );

   aead_pp_piso #(.IN_W(TAG_W), .W(DATA_W), .LEN_W(LEN_W)) u_tag_piso (
      .clk(clk), .rst_n(rst_n),
      .in_data(tag_data), .in_valid(tag_valid), .in_ready(tag_ready),
      .rem(rem_q), .take(tag_take),
      .word_data(tag_word), .word_valid(tag_wvalid)
   );

   aead_pp_auxfifo #(.W(DATA_W), .DEPTH(AUX_DEPTH)) u_aux (
      .clk(clk), .rst_n(rst_n),
      .push(aux_push), .push_data(aux_push_data),
      .pop(aux_pop), .flush(aux_flush),
      .head(aux_head), .empty(aux_empty), .full(aux_full)
   );

   always_comb begin
      out_valid     = 1'b0;
      out_data      = '0;
      byp_ready     = 1'b0;
      blk_take      = 1'b0;
      tag_take      = 1'b0;
      aux_push      = 1'b0;
      aux_push_data = byp_data;
      aux_pop       = 1'b0;
      aux_flush     = 1'b0;
      auth_ready    = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            byp_ready = 1'b1;
            aux_push  = byp_valid && (in_type == SEG_PT);
         end
         S_HDR: begin
            out_valid = 1'b1;
            out_data  = hdr_q;
         end
         S_PASS: begin
            out_valid = byp_valid;
            out_data  = byp_data;
            byp_ready = out_ready;
         end
         S_CT: begin
            out_valid = blk_wvalid;
            out_data  = blk_word;
            blk_take  = out_ready && blk_wvalid;
         end
         S_TAGH: begin
            out_valid = 1'b1;
            out_data  = tag_hdr_word;
         end
         S_TAG: begin
            out_valid = tag_wvalid;
            out_data  = tag_word;
            tag_take  = out_ready && tag_wvalid;
         end
         S_DMSG: begin
            aux_push      = blk_wvalid && !aux_full;
            aux_push_data = blk_word;
            blk_take      = blk_wvalid && !aux_full;
         end
         S_WAUTH: begin
            auth_ready = 1'b1;
            aux_flush  = auth_valid && !auth_ok;
         end
         S_DRAIN: begin
            out_valid = !aux_empty;
            out_data  = aux_head;
            aux_pop   = out_ready && !aux_empty;
         end
         S_STAT: begin
            out_valid = 1'b1;
            out_data  = stat_word;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         hdr_q   <= '0;
         rem_q   <= '0;
         eot_q   <= 1'b0;
         ok_q    <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: if (byp_valid) begin
               hdr_q <= byp_data;
               rem_q <= in_len;
               eot_q <= in_eot;
               if (in_type == SEG_PT) begin
                  if (in_len != '0)  state_q <= S_DMSG;
                  else if (in_eot)   state_q <= S_WAUTH;
               end else begin
                  state_q <= S_HDR;
               end
            end
            S_HDR: if (out_ready) begin
               if (hdr_type == SEG_CT) begin
                  if (rem_q != '0)  state_q <= S_CT;
                  else if (eot_q)   state_q <= S_TAGH;
                  else              state_q <= S_IDLE;
               end else begin
                  state_q <= (rem_q != '0) ? S_PASS : S_IDLE;
               end
            end
            S_PASS: if (byp_valid && out_ready) begin
               rem_q <= rem_step;
               if (last_step) state_q <= S_IDLE;
            end
            S_CT: if (blk_take) begin
               rem_q <= rem_step;
               if (last_step) state_q <= eot_q ? S_TAGH : S_IDLE;
            end
            S_TAGH: if (out_ready) begin
               rem_q   <= TAG_BYTES;
               state_q <= S_TAG;
            end
            S_TAG: if (tag_take) begin
               rem_q <= rem_step;
               if (last_step) begin
                  ok_q    <= 1'b1;
                  state_q <= S_STAT;
               end
            end
            S_DMSG: if (blk_take) begin
               rem_q <= rem_step;
               if (last_step) state_q <= eot_q ? S_WAUTH : S_IDLE;
            end
            S_WAUTH: if (auth_valid) begin
               ok_q    <= auth_ok;
               state_q <= auth_ok ? S_DRAIN : S_STAT;
            end
            S_DRAIN: if (aux_empty) state_q <= S_STAT;
            S_STAT:  if (out_ready) state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R10: a stalled word stays offered and unchanged
   assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R9: a failing result leaves nothing held
   assert_flush_on_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
      auth_valid && auth_ready && !auth_ok |=> aux_empty);

   // R8: a passing result keeps the held words for release
   assert_keep_on_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      auth_valid && auth_ready && auth_ok |=> !aux_empty);

endmodule

// File: tb/tb_aead_pp_top.sv
module tb_aead_pp_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [31:0]  byp_data;
   logic         byp_valid, byp_ready;
   logic [127:0] blk_data;
   logic         blk_valid, blk_ready;
   logic [127:0] tag_data;
   logic         tag_valid, tag_ready;
   logic         auth_valid, auth_ok, auth_ready;
   logic [31:0]  out_data;
   logic         out_valid, out_ready;

   always #4 clk = ~clk;

   aead_pp_top #(.DATA_W(32), .BLOCK_W(128), .TAG_W(128), .AUX_DEPTH(16)) dut (
      .clk(clk), .rst_n(rst_n),
      .byp_data(byp_data), .byp_valid(byp_valid), .byp_ready(byp_ready),
      .blk_data(blk_data), .blk_valid(blk_valid), .blk_ready(blk_ready),
      .tag_data(tag_data), .tag_valid(tag_valid), .tag_ready(tag_ready),
      .auth_valid(auth_valid), .auth_ok(auth_ok), .auth_ready(auth_ready),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int hs_cnt = 0;
   bit rdy_random = 1'b0;
   logic [31:0] exp_q[$];
   string       req_q[$];
   int          hs_cyc[$];
   bit          prev_stall = 1'b0;
   logic [31:0] prev_data;

   task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(input logic [3:0] t, input bit eoi, input bit eot, input logic [15:0] len);
      return {t, eoi, eot, 10'b0, len};
   endfunction

   function automatic logic [31:0] mword(input logic [127:0] b, input int k, input int rem);
      logic [31:0] w;
      w = b[127-32*k -: 32];
      for (int j = 0; j < 4; j++) if (j >= rem) w[31-8*j -: 8] = 8'h00;
      return w;
   endfunction

   task automatic expect_w(input logic [31:0] w, input string req);
      exp_q.push_back(w);
      req_q.push_back(req);
   endtask

   // monitor / scoreboard
   initial begin
      out_ready = 1'b1;
      forever begin
         @(negedge clk);
         cyc++;
         out_ready = rdy_random ? ($urandom_range(0, 1) == 1) : 1'b1;
         #2;
         if (rst_n) begin
            if (prev_stall) check(out_valid && out_data == prev_data, "R10", out_data, prev_data);
            if (out_valid && out_ready) begin
               hs_cnt++;
               hs_cyc.push_back(cyc);
               if (exp_q.size() == 0) begin
                  check(1'b0, "R9/R5 unexpected word", out_data, 32'h0);
               end else begin
                  logic [31:0] e;
                  string r;
                  e = exp_q.pop_front();
                  r = req_q.pop_front();
                  check(out_data == e, r, out_data, e);
               end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
         end
      end
   end

   task automatic byp_send(input logic [31:0] w);
      bit ok = 1'b0;
      @(negedge clk);
      byp_valid = 1'b1;
      byp_data  = w;
      while (!ok) begin
         #1 ok = byp_ready;
         @(posedge clk);
         if (!ok) @(negedge clk);
      end
      #1 byp_valid = 1'b0;
   endtask

   task automatic blk_send(input logic [127:0] b);
      bit ok = 1'b0;
      @(negedge clk);
      blk_valid = 1'b1;
      blk_data  = b;
      while (!ok) begin
         #1 ok = blk_ready;
         @(posedge clk);
         if (!ok) @(negedge clk);
      end
      #1 blk_valid = 1'b0;
   endtask

   task automatic tag_send(input logic [127:0] t);
      bit ok = 1'b0;
      @(negedge clk);
      tag_valid = 1'b1;
      tag_data  = t;
      while (!ok) begin
         #1 ok = tag_ready;
         @(posedge clk);
         if (!ok) @(negedge clk);
      end
      #1 tag_valid = 1'b0;
   endtask

   task automatic auth_send(input bit pass);
      bit ok = 1'b0;
      @(negedge clk);
      auth_valid = 1'b1;
      auth_ok    = pass;
      while (!ok) begin
         #1 ok = auth_ready;
         @(posedge clk);
         if (!ok) @(negedge clk);
      end
      #1 auth_valid = 1'b0;
   endtask

   task automatic wait_drain();
      int t = 0;
      while (exp_q.size() != 0 && t < 3000) begin
         @(posedge clk);
         t++;
      end
      repeat (4) @(posedge clk);
   endtask

   // encryption segment with tag: header, masked words, tag header, tag, status
   task automatic run_ct_final(input logic [127:0] b, input logic [127:0] t);
      expect_w(hdr(4'h4, 1'b0, 1'b1, 16'd7), "R4 ct header");
      expect_w(mword(b, 0, 7), "R4 ct word0");
      expect_w(mword(b, 1, 3), "R5 ct masked word1");
      expect_w(hdr(4'h5, 1'b1, 1'b1, 16'd16), "R6 tag header");
      for (int k = 0; k < 4; k++) expect_w(t[127-32*k -: 32], "R6 tag word");
      expect_w(32'hE000_0000, "R6 success status");
      fork
         byp_send(hdr(4'h4, 1'b0, 1'b1, 16'd7));
         blk_send(b);
         tag_send(t);
      join
      wait_drain();
   endtask

   task automatic run_ct22(input logic [127:0] b1, input logic [127:0] b2);
      expect_w(hdr(4'h4, 1'b0, 1'b0, 16'd22), "R4 ct header");
      for (int k = 0; k < 4; k++) expect_w(mword(b1, k, 4), "R4 block1 word");
      expect_w(mword(b2, 0, 4), "R4 block2 word0");
      expect_w(mword(b2, 1, 2), "R5 block2 masked word1");
      fork
         byp_send(hdr(4'h4, 1'b0, 1'b0, 16'd22));
         begin blk_send(b1); blk_send(b2); end
      join
      wait_drain();
   endtask

   task automatic run_ad10();
      expect_w(hdr(4'h2, 1'b0, 1'b1, 16'd10), "R3 ad header");
      expect_w(32'hA1A2A3A4, "R3 ad word0");
      expect_w(32'hB1B2B3B4, "R3 ad word1");
      expect_w(32'hC1C2C3C4, "R3 ad partial word unchanged");
      byp_send(hdr(4'h2, 1'b0, 1'b1, 16'd10));
      byp_send(32'hA1A2A3A4);
      byp_send(32'hB1B2B3B4);
      byp_send(32'hC1C2C3C4);
      wait_drain();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [127:0] b1, b2, t1;
      int snap;
      rst_n = 1'b0;
      byp_valid = 1'b0; byp_data = '0;
      blk_valid = 1'b0; blk_data = '0;
      tag_valid = 1'b0; tag_data = '0;
      auth_valid = 1'b0; auth_ok = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      check(out_valid == 1'b0, "R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
      check(byp_ready && blk_ready, "R1 ready in reset", {30'b0, byp_ready, blk_ready}, 32'h3);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(out_valid == 1'b0, "R1 out_valid after reset", {31'b0, out_valid}, 32'h0);

      b1 = 128'h00112233_44556677_8899AABB_CCDDEEFF;
      b2 = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
      t1 = 128'h5A5A0001_5A5A0002_5A5A0003_5A5A0004;

      // R3 bypass segment, R2 header layout
      run_ad10();

      // R4/R5 ciphertext crossing a block, partial last word
      run_ct22(b1, b2);

      // R11 back-to-back blocks with ready high
      hs_cyc.delete();
      expect_w(hdr(4'h4, 1'b0, 1'b0, 16'd32), "R11 ct header");
      for (int k = 0; k < 4; k++) expect_w(b2[127-32*k -: 32], "R11 block1 word");
      for (int k = 0; k < 4; k++) expect_w(b1[127-32*k -: 32], "R11 block2 word");
      fork
         byp_send(hdr(4'h4, 1'b0, 1'b0, 16'd32));
         begin blk_send(b2); blk_send(b1); end
      join
      wait_drain();
      check(hs_cyc.size() == 9 && hs_cyc[8] - hs_cyc[0] == 8, "R11 no idle cycle",
            32'(hs_cyc.size() == 9 ? hs_cyc[8] - hs_cyc[0] : -1), 32'd8);

      // R6 encryption end with tag and status
      run_ct_final(b1, t1);

      // R6 zero-length final ciphertext
      expect_w(hdr(4'h4, 1'b0, 1'b1, 16'd0), "R6 empty ct header");
      expect_w(hdr(4'h5, 1'b1, 1'b1, 16'd16), "R6 tag header after empty ct");
      for (int k = 0; k < 4; k++) expect_w(b2[127-32*k -: 32], "R6 tag word");
      expect_w(32'hE000_0000, "R6 success status");
      fork
         byp_send(hdr(4'h4, 1'b0, 1'b1, 16'd0));
         tag_send(b2);
      join
      wait_drain();

      // R3 zero-length bypass segment: header only
      expect_w(hdr(4'h1, 1'b0, 1'b0, 16'd0), "R3 empty segment header");
      byp_send(hdr(4'h1, 1'b0, 1'b0, 16'd0));
      wait_drain();

      // R7/R8 decryption, passing result
      fork
         byp_send(hdr(4'h3, 1'b1, 1'b1, 16'd9));
         blk_send(b1);
      join
      snap = hs_cnt;
      repeat (20) @(posedge clk);
      check(hs_cnt == snap, "R7 held while waiting", 32'(hs_cnt), 32'(snap));
      expect_w(hdr(4'h3, 1'b1, 1'b1, 16'd9), "R8 released header");
      expect_w(mword(b1, 0, 9), "R8 released word0");
      expect_w(mword(b1, 1, 5), "R8 released word1");
      expect_w(mword(b1, 2, 1), "R5 released masked word2");
      expect_w(32'hE000_0000, "R8 success status");
      auth_send(1'b1);
      wait_drain();

      // R9 decryption, failing result
      fork
         byp_send(hdr(4'h3, 1'b1, 1'b1, 16'd20));
         begin blk_send(b2); blk_send(b1); end
      join
      snap = hs_cnt;
      repeat (10) @(posedge clk);
      check(hs_cnt == snap, "R7 held before failing result", 32'(hs_cnt), 32'(snap));
      expect_w(32'hF000_0000, "R9 failure status");
      auth_send(1'b0);
      wait_drain();
      check(hs_cnt == snap + 1, "R9 only status emitted", 32'(hs_cnt - snap), 32'd1);
      run_ad10();

      // R10 random backpressure over all paths
      rdy_random = 1'b1;
      run_ct22(b2, b1);
      run_ct_final(b2, t1);
      run_ad10();
      fork
         byp_send(hdr(4'h3, 1'b1, 1'b1, 16'd5));
         blk_send(b2);
      join
      expect_w(hdr(4'h3, 1'b1, 1'b1, 16'd5), "R8 released header under stall");
      expect_w(mword(b2, 0, 5), "R8 released word0 under stall");
      expect_w(mword(b2, 1, 1), "R5 released masked word under stall");
      expect_w(32'hE000_0000, "R8 success status under stall");
      auth_send(1'b1);
      wait_drain();
      rdy_random = 1'b0;
      repeat (4) @(posedge clk);

      check(exp_q.size() == 0, "R10 all expected words seen", 32'(exp_q.size()), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule